// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with DMA Request

This block buffers outgoing audio samples between a 32-bit register bus and a serial audio transmitter. Software or a DMA engine writes samples to a write-only data address. The FIFO stores them, and the transmitter takes them one at a time with a pop strobe. A mode bit sets whether the significant bits of each written word sit at the top or at the bottom of the 32-bit word.

A single control bit flushes the FIFO. The bit clears itself after one cycle. A 32-bit counter of transmitted samples keeps running and software can reload it. A DMA request tells the DMA engine that a whole burst of samples fits in the free space. The request is gated by its own enable bit.

To bring the block up, software flushes the FIFO, clears the counter, sets the transmit enable and then sets the DMA request enable. To stop, it clears both enables.

Top module: `aud_tx_fifo`

## Requirements
- R1: After reset, the FIFO control register (byte offset 0x04) reads 0x000400F0. The transmit control register (0x00), the DMA control register (0x0C) and the sample counter (0x10) read 0. `sample_valid_o` and `dma_req_o` are low.
- R2: A write to the sample data address (0x08) pushes one sample. Samples leave in the order they were written. A read of 0x08 returns 0.
- R3: FIFO control bit 2 selects the alignment. When it is 0, the stored sample is bits [31:32-SAMPLE_W] of the written word. When it is 1, the stored sample is bits [SAMPLE_W-1:0].
- R4: A push while DEPTH samples are held is dropped. The held samples are unchanged, and after DEPTH pops the FIFO is empty.
- R5: A pop is taken only while transmit enable (bit 0 of 0x00) is 1 and a sample is held. A pop while the enable is 0 leaves the head sample and the counter unchanged.
- R6: A write of FIFO control with bit 25 set empties the FIFO at that clock edge. Bit 25 reads 1 for exactly one cycle and then 0. The other written bits are kept, and the sample counter is not changed.
- R7: The sample counter increments once per pop that is taken, and wraps from 0xFFFFFFFF to 0. A write to 0x10 loads the written value, so writing 0 clears it. That write takes priority over a pop in the same cycle.
- R8: `dma_req_o` is high exactly when DMA enable (bit 7 of 0x0C) is 1 and at least BURST entries are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| pop_i | input | 1 | Transmitter takes the head sample |
| sample_o | output | SAMPLE_W | Head sample |
| sample_valid_o | output | 1 | FIFO holds at least one sample |
| tx_en_o | output | 1 | Transmit enable, sent to the transmitter |
| dma_req_o | output | 1 | A DMA burst fits in the FIFO |

## Verification
The hardest cases to reach are those where a flush, a counter write, a push or a pop lands on the same edge as another event. These are the flush on a non-empty FIFO, the counter reload on the same edge as a pop, and the wrap from all ones. The bench drives the pop strobe and the bus write together in one cycle. It preloads the counter with 0xFFFFFFFF before a pop. It also sweeps every fill level from empty to full, with the DMA enable both on and off, and compares the request against the free space it computes itself.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int unsigned BUS_W = 32;
  localparam logic [5:0] OFS_CTRL  = 6'h00;
  localparam logic [5:0] OFS_FCTL  = 6'h04;
  localparam logic [5:0] OFS_DATA  = 6'h08;
  localparam logic [5:0] OFS_DMA   = 6'h0C;
  localparam logic [5:0] OFS_CNT   = 6'h10;
  localparam logic [BUS_W-1:0] FCTL_RST = 32'h0004_00F0;
  localparam int unsigned FLUSH_BIT = 25;
  localparam int unsigned MODE_BIT  = 2;
  localparam int unsigned DREQ_BIT  = 7;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_FCTL, SEL_DATA, SEL_DMA, SEL_CNT
  } reg_sel_e;
endpackage

// File: rtl/aud_tx_regs.sv
module aud_tx_regs
  import aud_tx_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  input  logic                pop_ok_i,
  output logic                tx_en_o,
  output logic                dreq_en_o,
  output logic                flush_o,
  output logic                flush_bit_o,
  output logic                cnt_wr_o,
  output logic [BUS_W-1:0]    cnt_o,
  output logic                push_o,
  output logic [SAMPLE_W-1:0] push_data_o
);
  reg_sel_e         sel;
  logic [BUS_W-1:0] fctl_q, cnt_q;
  logic             tx_en_q, dreq_en_q;

  always_comb begin
    unique case (BUS_W'(addr_i))
      BUS_W'(OFS_CTRL): sel = SEL_CTRL;
      BUS_W'(OFS_FCTL): sel = SEL_FCTL;
      BUS_W'(OFS_DATA): sel = SEL_DATA;
      BUS_W'(OFS_DMA):  sel = SEL_DMA;
      BUS_W'(OFS_CNT):  sel = SEL_CNT;
      default:          sel = SEL_NONE;
    endcase
  end

  assign flush_o  = we_i && (sel == SEL_FCTL) && wdata_i[FLUSH_BIT];
  assign cnt_wr_o = we_i && (sel == SEL_CNT);
  assign push_o   = we_i && (sel == SEL_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fctl_q    <= FCTL_RST;
      tx_en_q   <= 1'b0;
      dreq_en_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (we_i && sel == SEL_FCTL) fctl_q <= wdata_i;
      else                         fctl_q[FLUSH_BIT] <= 1'b0; // self-clearing
      if (we_i && sel == SEL_CTRL) tx_en_q   <= wdata_i[0];
      if (we_i && sel == SEL_DMA)  dreq_en_q <= wdata_i[DREQ_BIT];
      if (cnt_wr_o)      cnt_q <= wdata_i;
      else if (pop_ok_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  // Alignment of significant bits in a written word
  always_comb begin
    if (fctl_q[MODE_BIT]) push_data_o = wdata_i[SAMPLE_W-1:0];
    else                  push_data_o = wdata_i[BUS_W-1 -: SAMPLE_W];
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CTRL: rdata_o[0] = tx_en_q;
      SEL_FCTL: rdata_o = fctl_q;
      SEL_DMA:  rdata_o[DREQ_BIT] = dreq_en_q;
      SEL_CNT:  rdata_o = cnt_q;
      default:  rdata_o = '0; // data address is write-only
    endcase
  end

  assign tx_en_o     = tx_en_q;
  assign dreq_en_o   = dreq_en_q;
  assign flush_bit_o = fctl_q[FLUSH_BIT];
  assign cnt_o       = cnt_q;
endmodule

// File: rtl/aud_tx_sfifo.sv
module aud_tx_sfifo #(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned SAMPLE_W = 24,
  localparam int unsigned PTR_W   = $clog2(DEPTH),
  localparam int unsigned LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                push_i,
  input  logic [SAMPLE_W-1:0] push_data_i,
  input  logic                pop_i,
  output logic [SAMPLE_W-1:0] head_o,
  output logic [LVL_W-1:0]    level_o
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic [LVL_W-1:0]    level;
  logic                push_ok;

  assign push_ok = push_i && (level != LVL_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_i)   rd_ptr <= rd_ptr + 1'b1;
      level <= level + LVL_W'(push_ok) - LVL_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem[wr_ptr] <= push_data_i;
  end

  assign head_o  = mem[rd_ptr];
  assign level_o = level;
endmodule

// File: rtl/aud_tx_dreq.sv
module aud_tx_dreq #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned BURST = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             en_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             req_o
);
  logic [LVL_W-1:0] free;
  assign free  = LVL_W'(DEPTH) - level_i;
  assign req_o = en_i && (free >= LVL_W'(BURST));
endmodule

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo
  import aud_tx_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned BURST    = 4,
  localparam int unsigned LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic                pop_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_valid_o,
  output logic                tx_en_o,
  output logic                dma_req_o
);
  logic                tx_en, dreq_en, flush, flush_bit, cnt_wr, pop_ok, push;
  logic [BUS_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] push_data;
  logic [LVL_W-1:0]    level;

  assign sample_valid_o = (level != '0);
  assign pop_ok  = pop_i && tx_en && sample_valid_o && !flush;
  assign tx_en_o = tx_en;

  aud_tx_regs #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .pop_ok_i(pop_ok),
    .tx_en_o(tx_en), .dreq_en_o(dreq_en), .flush_o(flush),
    .flush_bit_o(flush_bit), .cnt_wr_o(cnt_wr), .cnt_o(cnt),
    .push_o(push), .push_data_o(push_data)
  );

  aud_tx_sfifo #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i(flush), .push_i(push), .push_data_i(push_data),
    .pop_i(pop_ok), .head_o(sample_o), .level_o(level)
  );

  aud_tx_dreq #(.DEPTH(DEPTH), .BURST(BURST)) u_dreq (
    .en_i(dreq_en), .level_i(level), .req_o(dma_req_o)
  );
endmodule

// File: rtl/aud_tx_fifo_chk.sv
module aud_tx_fifo_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned BURST = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dma_req_o,
  input logic             dreq_en,
  input logic [LVL_W-1:0] level,
  input logic             flush,
  input logic             flush_bit,
  input logic             pop_ok,
  input logic             cnt_wr,
  input logic [31:0]      cnt
);
  AST_DREQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dreq_en |-> !dma_req_o); // R8
  AST_DREQ_SPACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (level <= LVL_W'(DEPTH - BURST))); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level <= LVL_W'(DEPTH)); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (level == '0)); // R6
  AST_FLUSH_SELFCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_bit && !flush) |=> !flush_bit); // R6
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_ok && !cnt_wr) |=> (cnt == $past(cnt) + 32'd1)); // R7
endmodule

bind aud_tx_fifo aud_tx_fifo_chk #(.DEPTH(DEPTH), .BURST(BURST)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dma_req_o(dma_req_o), .dreq_en(dreq_en),
  .level(level), .flush(flush), .flush_bit(flush_bit), .pop_ok(pop_ok),
  .cnt_wr(cnt_wr), .cnt(cnt)
);

// File: tb/aud_tx_fifo_tb.sv
module aud_tx_fifo_tb;
  localparam int unsigned ADDR_W = 6, SW = 24, DEPTH = 8, BURST = 4;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          we = 1'b0, pop = 1'b0;
  logic [5:0]    addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [SW-1:0] sample;
  logic          valid, tx_en, dreq;
  int            checks = 0, errors = 0, cycles = 0;
  logic [31:0]   ecnt = 0;

  always #5 clk = ~clk;

  aud_tx_fifo #(.ADDR_W(ADDR_W), .SAMPLE_W(SW), .DEPTH(DEPTH), .BURST(BURST)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pop_i(pop),
    .sample_o(sample), .sample_valid_o(valid), .tx_en_o(tx_en), .dma_req_o(dreq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 50000) begin
        errors++;
        $display("FAIL watchdog act=%0d exp=%0d", cycles, 50000);
        summary();
      end
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(6'h04, r); check("R1 fctl", r, 32'h0004_00F0);
    rd(6'h00, r); check("R1 ctrl", r, 0);
    rd(6'h0C, r); check("R1 dma", r, 0);
    rd(6'h10, r); check("R1 cnt", r, 0);
    check("R1 valid", {31'b0, valid}, 0);
    check("R1 dreq", {31'b0, dreq}, 0);

    // bring-up: flush, clear counter, enable tx
    wr(6'h04, 32'h0204_00F0);
    wr(6'h10, 0);
    wr(6'h00, 1);

    // R2 R3 ordering, MSB alignment (mode 0)
    for (int i = 0; i < DEPTH; i++) wr(6'h08, 32'hA000_0000 + i * 32'h0101_0111);
    rd(6'h08, r); check("R2 data read", r, 0);
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] w;
      w = 32'hA000_0000 + i * 32'h0101_0111;
      check("R2 R3 msb order", {8'b0, sample}, {8'b0, w[31:8]});
      do_pop(); ecnt++;
    end
    check("R2 empty", {31'b0, valid}, 0);

    // R3 LSB alignment (mode 1)
    wr(6'h04, 32'h0004_00F4);
    for (int i = 0; i < 4; i++) wr(6'h08, 32'h5C00_0000 | (i * 32'h0003_0507));
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w;
      w = 32'h5C00_0000 | (i * 32'h0003_0507);
      check("R3 lsb", {8'b0, sample}, {8'b0, w[23:0]});
      do_pop(); ecnt++;
    end

    // R4 overflow dropped
    for (int i = 0; i < DEPTH + 2; i++) wr(6'h08, 32'h100 + i);
    for (int i = 0; i < DEPTH; i++) begin
      check("R4 kept", {8'b0, sample}, 32'h100 + i);
      do_pop(); ecnt++;
    end
    check("R4 empty after drain", {31'b0, valid}, 0);

    // R5 pop ignored while disabled
    wr(6'h08, 32'h77);
    wr(6'h00, 0);
    do_pop();
    check("R5 head kept", {8'b0, sample}, 32'h77);
    check("R5 valid kept", {31'b0, valid}, 1);
    rd(6'h10, r); check("R5 cnt kept", r, ecnt);
    wr(6'h00, 1);
    do_pop(); ecnt++;
    check("R5 pop when enabled", {31'b0, valid}, 0);

    // R6 flush
    for (int i = 0; i < 3; i++) wr(6'h08, i);
    wr(6'h04, 32'h0204_00F4);
    check("R6 emptied", {31'b0, valid}, 0);
    rd(6'h04, r); check("R6 bit set one cycle", r, 32'h0204_00F4);
    @(negedge clk);
    rd(6'h04, r); check("R6 bit cleared", r, 32'h0004_00F4);
    rd(6'h10, r); check("R6 cnt untouched", r, ecnt);

    // R7 counter
    rd(6'h10, r); check("R7 count pops", r, 32'd21);
    wr(6'h10, 0);
    rd(6'h10, r); check("R7 clear", r, 0);
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h08, 1);
    do_pop();
    rd(6'h10, r); check("R7 wrap", r, 0);
    wr(6'h08, 2);
    @(negedge clk); we = 1'b1; addr = 6'h10; wdata = 5; pop = 1'b1;
    @(negedge clk); we = 1'b0; pop = 1'b0;
    rd(6'h10, r); check("R7 write wins", r, 5);
    check("R7 pop taken", {31'b0, valid}, 0);

    // R8 dma request sweep over fill level and enable
    for (int en = 0; en < 2; en++) begin
      wr(6'h0C, en ? 32'h80 : 32'h0);
      for (int n = 0; n <= DEPTH; n++) begin
        check("R8 dreq", {31'b0, dreq}, {31'b0, (en == 1) && (DEPTH - n >= BURST)});
        if (n < DEPTH) wr(6'h08, n);
      end
      wr(6'h04, 32'h0204_00F0);
      check("R8 dreq after flush", {31'b0, dreq}, {31'b0, en == 1});
    end
    wr(6'h00, 0);
    wr(6'h0C, 0);
    check("R8 stop", {31'b0, dreq}, 0);

    summary();
  end
endmodule